// File: doc/BRIEF.md
# Expansion Bus Width Adapter

This block sits between a 32-bit processor data bus and a narrow expansion peripheral whose data path is 8 or 16 bits wide. Software always makes word-aligned 32-bit accesses. For a write, the adapter takes the peripheral data from the upper half of the processor word, starting at bit 16. Software puts a halfword in bits 31:16 and also copies it into bits 15:0. A byte store already appears on every byte lane, so the peripheral's low byte comes from bits 23:16. For a read, the peripheral's data lines fill the low bits of the returned word. Every bit above them reads as 1, as an undriven line held high by a pull-up would.

Addresses are word-scaled. Peripheral register N sits at byte offset 4·N, and the two lowest processor address bits play no part. A request is accepted on a valid/ready handshake. An accepted write produces a one-cycle write strobe in the next cycle. An accepted read produces a one-cycle read strobe in the next cycle, and the response is returned in that same cycle. The peripheral width and the register index width are parameters.

Top module: `exp_width_bridge`

## Requirements
- R1: After reset, `cpu_req_ready` is 1 and `per_wr_strobe`, `per_rd_strobe` and `cpu_rsp_valid` are all 0.
- R2: In the strobe cycle of an accepted write, `per_wdata` equals the accepted `cpu_req_wdata[16 +: PER_DW]`: bits 31:16 when 16 wide, bits 23:16 when 8 wide.
- R3: Bits 15:0 of `cpu_req_wdata` have no effect on the value written to the peripheral.
- R4: Each accepted write gives exactly one `per_wr_strobe` pulse, one cycle long, in the cycle after acceptance.
- R5: In the strobe cycle, `per_addr` equals the accepted `cpu_req_addr[2 +: REG_AW]`, so register N is reached at byte offset 4·N. Address bits above `REG_AW+1` are ignored.
- R6: Address bits 1:0 are ignored, so a request with nonzero low bits is serviced at the aligned word.
- R7: An accepted read raises `cpu_rsp_valid` together with `per_rd_strobe` for exactly the cycle after acceptance. In that cycle `cpu_rsp_rdata[PER_DW-1:0]` equals `per_rdata`.
- R8: While `cpu_rsp_valid` is 1, `cpu_rsp_rdata[31:PER_DW]` is all ones.
- R9: `cpu_req_ready` is 0 in the cycle after an acceptance and 1 again in the cycle after that, so a request held valid is accepted once every two cycles.
- R10: A cycle without an accepted request produces no strobe and no response in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req_valid | input | 1 | Request present |
| cpu_req_ready | output | 1 | Adapter can accept a request this cycle |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Byte address from the processor |
| cpu_req_wdata | input | 32 | Processor write word |
| cpu_rsp_valid | output | 1 | Read data valid |
| cpu_rsp_rdata | output | 32 | Read word, with the upper bits pulled up |
| per_addr | output | REG_AW | Peripheral register index |
| per_wdata | output | PER_DW | Peripheral write data |
| per_wr_strobe | output | 1 | One-cycle write pulse |
| per_rd_strobe | output | 1 | One-cycle read pulse |
| per_rdata | input | PER_DW | Peripheral read data |

## Verification
The hardest case to reach from the ports is a request held valid through the busy cycle. The request must be refused for exactly one cycle and then accepted again, with no duplicate or missing strobe. The bench holds `cpu_req_valid` high across three edges and checks the strobe and ready pattern alternating. The ignored lower write lane and the ignored address bits are tested by writing values whose lower half or low address bits differ from the upper lane. Each value is then read back through a register model in the bench, at the aligned index.

// File: rtl/exp_bridge_pkg.sv
package exp_bridge_pkg;
   localparam int CPU_DW     = 32;
   localparam int LANE_LSB   = 16;
   localparam int WORD_SHIFT = 2;

   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } op_e;
endpackage

// File: rtl/exp_addr_map.sv
module exp_addr_map #(
   parameter int ADDR_W = 12,
   parameter int REG_AW = 3
) (
   input  logic [ADDR_W-1:0] byte_addr,
   output logic [REG_AW-1:0] reg_idx
);
   import exp_bridge_pkg::*;

   localparam int TOP_USED = WORD_SHIFT + REG_AW;

   // Index bits start at the word boundary; byte-offset bits are discarded.
   assign reg_idx = byte_addr[WORD_SHIFT +: REG_AW];

   logic unused_low;
   assign unused_low = ^byte_addr[WORD_SHIFT-1:0];

   generate
      if (ADDR_W > TOP_USED) begin : g_hi_drop
         logic unused_hi;
         assign unused_hi = ^byte_addr[ADDR_W-1:TOP_USED];
      end
   endgenerate
endmodule

// File: rtl/exp_wr_lane.sv
module exp_wr_lane #(
   parameter int PER_DW = 16
) (
   input  logic [31:0]       cpu_word,
   output logic [PER_DW-1:0] lane
);
   import exp_bridge_pkg::*;

   logic unused_lower_half;
   assign unused_lower_half = ^cpu_word[LANE_LSB-1:0];

   generate
      if (PER_DW == 16) begin : g_half
         assign lane = cpu_word[CPU_DW-1:LANE_LSB];
      end else begin : g_byte
         assign lane = cpu_word[LANE_LSB+7:LANE_LSB];
         logic unused_top_byte;
         assign unused_top_byte = ^cpu_word[CPU_DW-1:LANE_LSB+8];
      end
   endgenerate
endmodule

// File: rtl/exp_rd_fill.sv
module exp_rd_fill #(
   parameter int PER_DW = 16
) (
   input  logic [PER_DW-1:0] per_data,
   output logic [31:0]       cpu_word
);
   import exp_bridge_pkg::*;

   localparam int FILL_W = CPU_DW - PER_DW;

   generate
      if (FILL_W > 0) begin : g_fill
         assign cpu_word = {{FILL_W{1'b1}}, per_data};
      end else begin : g_full
         assign cpu_word = per_data;
      end
   endgenerate
endmodule

// File: rtl/exp_bridge_ctrl.sv
module exp_bridge_ctrl #(
   parameter int REG_AW = 3,
   parameter int PER_DW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [REG_AW-1:0] idx_in,
   input  logic [PER_DW-1:0] lane_in,
   output logic              req_ready,
   output logic              wr_strobe,
   output logic              rd_strobe,
   output logic [REG_AW-1:0] idx_q,
   output logic [PER_DW-1:0] lane_q
);
   import exp_bridge_pkg::*;

   logic busy;
   op_e  op_q;
   logic take;

   assign req_ready = !busy;
   assign take      = req_valid && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         op_q   <= OP_READ;
         idx_q  <= '0;
         lane_q <= '0;
      end else begin
         busy <= take;
         if (take) begin
            op_q   <= req_write ? OP_WRITE : OP_READ;
            idx_q  <= idx_in;
            lane_q <= lane_in;
         end
      end
   end

   assign wr_strobe = busy && (op_q == OP_WRITE);
   assign rd_strobe = busy && (op_q == OP_READ);
endmodule

// File: rtl/exp_width_bridge.sv
module exp_width_bridge #(
   parameter int PER_DW = 16,
   parameter int REG_AW = 3,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   output logic              cpu_req_ready,
   input  logic              cpu_req_write,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   input  logic [31:0]       cpu_req_wdata,
   output logic              cpu_rsp_valid,
   output logic [31:0]       cpu_rsp_rdata,
   output logic [REG_AW-1:0] per_addr,
   output logic [PER_DW-1:0] per_wdata,
   output logic              per_wr_strobe,
   output logic              per_rd_strobe,
   input  logic [PER_DW-1:0] per_rdata
);
   import exp_bridge_pkg::*;

   generate
      if (!(PER_DW == 8 || PER_DW == 16)) begin : g_bad_width
         $error("exp_width_bridge: PER_DW must be 8 or 16");
      end
      if (ADDR_W < REG_AW + WORD_SHIFT) begin : g_bad_addr
         $error("exp_width_bridge: ADDR_W too small for REG_AW");
      end
      if (REG_AW < 1) begin : g_bad_idx
         $error("exp_width_bridge: REG_AW must be at least 1");
      end
   endgenerate

   logic [REG_AW-1:0] idx_c;
   logic [PER_DW-1:0] lane_c;

   exp_addr_map #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_map (
      .byte_addr (cpu_req_addr),
      .reg_idx   (idx_c)
   );

   exp_wr_lane #(.PER_DW(PER_DW)) u_lane (
      .cpu_word (cpu_req_wdata),
      .lane     (lane_c)
   );

   exp_bridge_ctrl #(.REG_AW(REG_AW), .PER_DW(PER_DW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (cpu_req_valid),
      .req_write (cpu_req_write),
      .idx_in    (idx_c),
      .lane_in   (lane_c),
      .req_ready (cpu_req_ready),
      .wr_strobe (per_wr_strobe),
      .rd_strobe (per_rd_strobe),
      .idx_q     (per_addr),
      .lane_q    (per_wdata)
   );

   exp_rd_fill #(.PER_DW(PER_DW)) u_fill (
      .per_data (per_rdata),
      .cpu_word (cpu_rsp_rdata)
   );

   assign cpu_rsp_valid = per_rd_strobe;
endmodule

// File: rtl/exp_width_bridge_chk.sv
module exp_width_bridge_chk #(
   parameter int PER_DW = 16,
   parameter int REG_AW = 3,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req_valid,
   input logic              cpu_req_ready,
   input logic              cpu_req_write,
   input logic [ADDR_W-1:0] cpu_req_addr,
   input logic [31:0]       cpu_req_wdata,
   input logic              cpu_rsp_valid,
   input logic [31:0]       cpu_rsp_rdata,
   input logic [REG_AW-1:0] per_addr,
   input logic [PER_DW-1:0] per_wdata,
   input logic              per_wr_strobe,
   input logic              per_rd_strobe,
   input logic [PER_DW-1:0] per_rdata
);
   logic acc;
   assign acc = cpu_req_valid && cpu_req_ready;

   assert_wdata_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cpu_req_write) |=> (per_wdata == $past(cpu_req_wdata[16 +: PER_DW])));

   assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cpu_req_write) |=> per_wr_strobe);

   assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      per_wr_strobe |=> !per_wr_strobe);

   assert_addr_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (per_addr == $past(cpu_req_addr[2 +: REG_AW])));

   assert_rsp_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !cpu_req_write) |=> (cpu_rsp_valid && per_rd_strobe && !per_wr_strobe));

   assert_rsp_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rsp_valid |-> (cpu_rsp_rdata[PER_DW-1:0] == per_rdata));

   assert_fill_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rsp_valid |-> (&cpu_rsp_rdata[31:PER_DW]));

   assert_busy_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> !cpu_req_ready);

   assert_ready_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req_ready |=> cpu_req_ready);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> (!per_wr_strobe && !per_rd_strobe && !cpu_rsp_valid));

   assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({per_wr_strobe, per_rd_strobe}));
endmodule

bind exp_width_bridge exp_width_bridge_chk #(
   .PER_DW(PER_DW), .REG_AW(REG_AW), .ADDR_W(ADDR_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_req_valid (cpu_req_valid),
   .cpu_req_ready (cpu_req_ready),
   .cpu_req_write (cpu_req_write),
   .cpu_req_addr  (cpu_req_addr),
   .cpu_req_wdata (cpu_req_wdata),
   .cpu_rsp_valid (cpu_rsp_valid),
   .cpu_rsp_rdata (cpu_rsp_rdata),
   .per_addr      (per_addr),
   .per_wdata     (per_wdata),
   .per_wr_strobe (per_wr_strobe),
   .per_rd_strobe (per_rd_strobe),
   .per_rdata     (per_rdata)
);

// File: tb/tb_exp_width_bridge.sv
`timescale 1ns/1ps
module tb_exp_width_bridge;
   localparam int PER_DW = 16;
   localparam int REG_AW = 3;
   localparam int ADDR_W = 12;
   localparam int NREG   = 1 << REG_AW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_req_valid = 1'b0;
   logic              cpu_req_ready;
   logic              cpu_req_write = 1'b0;
   logic [ADDR_W-1:0] cpu_req_addr = '0;
   logic [31:0]       cpu_req_wdata = '0;
   logic              cpu_rsp_valid;
   logic [31:0]       cpu_rsp_rdata;
   logic [REG_AW-1:0] per_addr;
   logic [PER_DW-1:0] per_wdata;
   logic              per_wr_strobe;
   logic              per_rd_strobe;
   logic [PER_DW-1:0] per_rdata;

   logic [PER_DW-1:0] pmem [NREG];
   logic [PER_DW-1:0] shadow [NREG];

   int n_checks = 0;
   int n_errors = 0;

   always #10 clk = ~clk;

   exp_width_bridge #(.PER_DW(PER_DW), .REG_AW(REG_AW), .ADDR_W(ADDR_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
      .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
      .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
      .cpu_rsp_rdata(cpu_rsp_rdata), .per_addr(per_addr),
      .per_wdata(per_wdata), .per_wr_strobe(per_wr_strobe),
      .per_rd_strobe(per_rd_strobe), .per_rdata(per_rdata)
   );

   // Peripheral register file model
   assign per_rdata = pmem[per_addr];
   always @(posedge clk) begin
      if (per_wr_strobe) pmem[per_addr] <= per_wdata;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive a write at a negedge, check the strobe cycle and the recovery cycle.
   task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_write = 1'b1;
      cpu_req_addr = a; cpu_req_wdata = d;
      @(negedge clk);
      cpu_req_valid = 1'b0; cpu_req_wdata = ~d;
      check("R4 wr strobe high", {31'd0, per_wr_strobe}, 32'd1);
      check("R5 per_addr", {29'd0, per_addr}, {29'd0, a[2 +: REG_AW]});
      check("R2 per_wdata lane", {16'd0, per_wdata}, {16'd0, d[31:16]});
      check("R9 ready low", {31'd0, cpu_req_ready}, 32'd0);
      shadow[a[2 +: REG_AW]] = d[31:16];
      @(negedge clk);
      check("R4 wr strobe single", {31'd0, per_wr_strobe}, 32'd0);
      check("R9 ready back", {31'd0, cpu_req_ready}, 32'd1);
   endtask

   task automatic do_read(input string req, input logic [ADDR_W-1:0] a);
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = a;
      @(negedge clk);
      cpu_req_valid = 1'b0;
      check({req, " R7 rsp valid"}, {31'd0, cpu_rsp_valid}, 32'd1);
      check({req, " R8 rdata"}, cpu_rsp_rdata, {16'hFFFF, shadow[a[2 +: REG_AW]]});
      @(negedge clk);
      check({req, " R7 rsp single"}, {31'd0, cpu_rsp_valid}, 32'd0);
   endtask

   task automatic t_reset;
      check("R1 ready", {31'd0, cpu_req_ready}, 32'd1);
      check("R1 wr strobe", {31'd0, per_wr_strobe}, 32'd0);
      check("R1 rd strobe", {31'd0, per_rd_strobe}, 32'd0);
      check("R1 rsp valid", {31'd0, cpu_rsp_valid}, 32'd0);
   endtask

   task automatic t_basic;
      do_write(12'h008, 32'h1234_1234);
      do_read("R5 idx2", 12'h008);
      do_read("R8 untouched idx7", 12'h01C);
   endtask

   task automatic t_lower_lane;
      do_write(12'h014, 32'hBEEF_0000);
      do_read("R3 idx5 zero low", 12'h014);
      do_write(12'h014, 32'h5A5A_C3C3);
      do_read("R3 idx5 mixed low", 12'h014);
   endtask

   task automatic t_low_addr;
      do_write(12'h01B, 32'h0F0F_0F0F);
      do_read("R6 idx6 via +1", 12'h019);
      do_write(12'h404, 32'h7777_0000);
      do_read("R5 high addr bit ignored", 12'h004);
   endtask

   task automatic t_idle;
      @(negedge clk);
      cpu_req_valid = 1'b0; cpu_req_write = 1'b1; cpu_req_wdata = 32'hDEAD_DEAD;
      cpu_req_addr = 12'h000;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         cpu_req_wdata = cpu_req_wdata ^ 32'hFFFF_FFFF;
         check("R10 no wr strobe", {31'd0, per_wr_strobe}, 32'd0);
         check("R10 no rsp", {31'd0, cpu_rsp_valid}, 32'd0);
      end
      do_read("R10 idx0 unchanged", 12'h000);
   endtask

   task automatic t_held_valid;
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_write = 1'b1;
      cpu_req_addr = 12'h00C; cpu_req_wdata = 32'hAAAA_5555;
      @(negedge clk);
      check("R9 held: strobe 1", {31'd0, per_wr_strobe}, 32'd1);
      check("R9 held: ready 0", {31'd0, cpu_req_ready}, 32'd0);
      cpu_req_wdata = 32'hCCCC_3333;
      @(negedge clk);
      check("R9 held: strobe 0", {31'd0, per_wr_strobe}, 32'd0);
      check("R9 held: ready 1", {31'd0, cpu_req_ready}, 32'd1);
      @(negedge clk);
      cpu_req_valid = 1'b0;
      check("R9 held: 2nd strobe", {31'd0, per_wr_strobe}, 32'd1);
      check("R2 held: 2nd data", {16'd0, per_wdata}, 32'h0000_CCCC);
      shadow[3] = 16'hCCCC;
      @(negedge clk);
      check("R4 held: no 3rd strobe", {31'd0, per_wr_strobe}, 32'd0);
      do_read("R9 idx3", 12'h00C);
   endtask

   initial begin
      #(200000 * 20);
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < NREG; i++) begin
         pmem[i]   = 16'hA000 + 16'(i);
         shadow[i] = 16'hA000 + 16'(i);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_lower_lane();
      t_low_addr();
      t_idle();
      t_held_valid();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule